// File: doc/BRIEF.md
# SDRAM command timing guard

This block sits on the command path between an SDRAM command sequencer and the memory. On every clock it looks at the command being requested: activate, read, write, precharge, auto refresh or mode register load, plus a two-bit bank number. It answers in the same cycle with a grant that says whether the command can go out now without breaking any minimum spacing. It keeps a set of down-counters for each bank and a few shared counters. Each counter is loaded when a command issues and must count down to zero before a command that depends on it may be granted.

All analogue spacings are parameters in picoseconds, together with the clock period. At elaboration each one is rounded up to a whole number of cycles. The spacings counted in clocks are parameters in cycles: mode-register recovery, CAS latency, burst length and write recovery. The sequencer may push a command through without a grant by raising a force input. Such a command still updates the timing state, and it also sets a sticky violation flag that only reset clears. The same flag is set when a bank stays open longer than the maximum row-active time.

Top module: `sdram_cmd_guard`

## Requirements
- R1: Each picosecond minimum becomes a cycle count equal to the time divided by the clock period, rounded up to the next whole cycle, with a floor of one cycle. With the defaults (7.5 ns clock): row-to-row 2, activate-to-column 3, row-active minimum 7, precharge-to-activate 2, activate-to-activate same bank 9, refresh cycle 11, row-active maximum 13334.
- R2: Activate and auto refresh are refused until 2 cycles after a granted or forced mode register load.
- R3: An activate is refused until the row-to-row spacing has elapsed since the previous activate to any bank.
- R4: Read and write are granted only to an open bank, and only once the activate-to-column spacing has elapsed since that bank's activate. Column commands otherwise need no gap between them.
- R5: A precharge is refused until the row-active minimum has elapsed since that bank's activate.
- R6: A precharge is refused until CAS latency + burst length − 2 cycles after a read to that bank, and until burst length + write recovery − 1 cycles after a write to it. With the defaults both gaps are 5 cycles.
- R7: An activate to an open bank is refused. An activate to a bank is also refused until the precharge-to-activate spacing has passed since that bank's precharge and the same-bank activate spacing has passed since its previous activate.
- R8: Auto refresh requires every bank closed and past its precharge-to-activate wait. After a refresh every command except NOP is refused for the refresh-cycle time.
- R9: A mode register load requires every bank closed and ready to activate.
- R10: A command with request valid and force high that would not be granted sets the violation output one cycle later. The flag stays high until reset.
- R11: A bank left open for the row-active maximum in cycles, counted from the cycle after its activate, sets the violation output on the following clock.
- R12: Grant is low whenever request valid is low. Reset closes all banks, clears every counter and clears the violation flag. Command encoding: 0 NOP (always granted), 1 activate, 2 read, 3 write, 4 precharge, 5 auto refresh, 6 mode register load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A command is requested this cycle |
| req_cmd | input | 3 | Command code (see R12) |
| req_bank | input | 2 | Target bank |
| req_force | input | 1 | Issue the command even without a grant |
| grant | output | 1 | The requested command may issue this cycle |
| violation | output | 1 | Sticky flag for a forced ungranted command or an overlong open row |

## Verification
A counter loaded with the wrong value, or not loaded at all, shows up as a grant that comes a cycle early or late. The error appears on the very first request that depends on that counter, so the test walks each spacing at its exact boundary: one cycle before release and the cycle of release. A wrong open/closed bank state shows up at once as a refused column command or an accepted refresh. A broken violation register shows one clock after the forced command, or one clock after the row-active maximum is reached.

// File: rtl/sdram_guard_pkg.sv
package sdram_guard_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6
  } cmd_e;

  // ceiling division of a time in ps by the clock period, never below one cycle
  function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
    int c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/sdram_gap_counter.sv
// Saturating down-counter; a load only raises the remaining wait.
module sdram_gap_counter #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         idle
);
  logic [W-1:0] cnt_q, dec;

  always_comb dec = (cnt_q == '0) ? '0 : cnt_q - W'(1);

  always_ff @(posedge clk) begin
    if (rst)                    cnt_q <= '0;
    else if (load && val > dec) cnt_q <= val;
    else                        cnt_q <= dec;
  end

  assign idle = (cnt_q == '0);

  // R7: without a load the wait never grows
  p_no_growth_r7: assert property (@(posedge clk) disable iff (rst)
    !load |=> (cnt_q <= $past(cnt_q)));

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
  import sdram_guard_pkg::*;
#(
  parameter int W       = 6,
  parameter int RW      = 14,
  parameter int RC_L    = 8,
  parameter int RP_L    = 1,
  parameter int RCD_L   = 2,
  parameter int RAS_L   = 6,
  parameter int RDPRE_L = 4,
  parameter int WRPRE_L = 4,
  parameter int RASMAX  = 13334
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  cmd_e cmd,
  input  logic sel,
  output logic act_rdy,
  output logic col_rdy,
  output logic pre_rdy,
  output logic is_open,
  output logic ras_over
);
  logic          hit;
  logic          act_ld, col_ld, pre_ld;
  logic [W-1:0]  act_val, pre_val;
  logic          act_idle, col_idle, pre_idle;
  logic          open_q;
  logic [RW-1:0] ras_q;

  assign hit     = issue && sel;
  assign act_ld  = hit && (cmd == CMD_ACT || cmd == CMD_PRE);
  assign act_val = (cmd == CMD_ACT) ? W'(RC_L) : W'(RP_L);
  assign col_ld  = hit && (cmd == CMD_ACT);
  assign pre_ld  = hit && (cmd == CMD_ACT || cmd == CMD_RD || cmd == CMD_WR);

  always_comb begin
    case (cmd)
      CMD_RD:  pre_val = W'(RDPRE_L);
      CMD_WR:  pre_val = W'(WRPRE_L);
      default: pre_val = W'(RAS_L);
    endcase
  end

  sdram_gap_counter #(.W(W)) u_act (.clk(clk), .rst(rst), .load(act_ld),
    .val(act_val), .idle(act_idle));
  sdram_gap_counter #(.W(W)) u_col (.clk(clk), .rst(rst), .load(col_ld),
    .val(W'(RCD_L)), .idle(col_idle));
  sdram_gap_counter #(.W(W)) u_pre (.clk(clk), .rst(rst), .load(pre_ld),
    .val(pre_val), .idle(pre_idle));

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      ras_q  <= '0;
    end else if (hit && cmd == CMD_ACT) begin
      open_q <= 1'b1;
      ras_q  <= RW'(1);
    end else if (hit && cmd == CMD_PRE) begin
      open_q <= 1'b0;
      ras_q  <= '0;
    end else if (open_q && ras_q != RW'(RASMAX)) begin
      ras_q  <= ras_q + RW'(1);
    end
  end

  assign act_rdy  = act_idle && !open_q;
  assign col_rdy  = col_idle && open_q;
  assign pre_rdy  = pre_idle;
  assign is_open  = open_q;
  assign ras_over = open_q && (ras_q == RW'(RASMAX));

  // R6: a read to this bank always holds off its precharge on the next cycle
  p_rd_pre_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (RDPRE_L > 0) && hit && cmd == CMD_RD |=> !pre_rdy);
  // R7: an activated bank cannot be activated again right away
  p_act_reopen_r7: assert property (@(posedge clk) disable iff (rst)
    hit && cmd == CMD_ACT |=> !act_rdy);

endmodule

// File: rtl/sdram_cmd_guard.sv
module sdram_cmd_guard
  import sdram_guard_pkg::*;
#(
  parameter int CLK_PS       = 7500,
  parameter int T_RRD_PS     = 15000,
  parameter int T_RCD_PS     = 20000,
  parameter int T_RP_PS      = 15000,
  parameter int T_RAS_PS     = 48000,
  parameter int T_RASMAX_PS  = 100_000_000,
  parameter int T_RC_PS      = 63000,
  parameter int T_RFC_PS     = 80000,
  parameter int MRD_CYC      = 2,
  parameter int CAS_LAT      = 3,
  parameter int BURST_LEN    = 4,
  parameter int WR_RECOV_CYC = 2,
  parameter int BANKS        = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_valid,
  input  logic [2:0]                 req_cmd,
  input  logic [$clog2(BANKS)-1:0]   req_bank,
  input  logic                       req_force,
  output logic                       grant,
  output logic                       violation
);
  localparam int RRD_C   = ps_to_cyc(T_RRD_PS, CLK_PS);
  localparam int RCD_C   = ps_to_cyc(T_RCD_PS, CLK_PS);
  localparam int RP_C    = ps_to_cyc(T_RP_PS, CLK_PS);
  localparam int RAS_C   = ps_to_cyc(T_RAS_PS, CLK_PS);
  localparam int RASMX_C = ps_to_cyc(T_RASMAX_PS, CLK_PS);
  localparam int RC_C    = ps_to_cyc(T_RC_PS, CLK_PS);
  localparam int RFC_C   = ps_to_cyc(T_RFC_PS, CLK_PS);
  localparam int RDPRE_C = (CAS_LAT + BURST_LEN - 2 < 1) ? 1 : CAS_LAT + BURST_LEN - 2;
  localparam int WRPRE_C = BURST_LEN + WR_RECOV_CYC - 1;
  localparam int CNT_W   = $clog2(RRD_C + RCD_C + RP_C + RAS_C + RC_C + RFC_C
                                  + RDPRE_C + WRPRE_C + MRD_CYC) + 1;
  localparam int RAS_W   = $clog2(RASMX_C + 1) + 1;

  cmd_e             cmd;
  logic             ok, issue;
  logic             rrd_idle, mrd_idle, rfc_idle;
  logic [BANKS-1:0] act_rdy, col_rdy, pre_rdy, open_v, over_v;
  logic             viol_q;

  assign cmd = cmd_e'(req_cmd);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    sdram_bank_timer #(
      .W(CNT_W), .RW(RAS_W), .RC_L(RC_C - 1), .RP_L(RP_C - 1),
      .RCD_L(RCD_C - 1), .RAS_L(RAS_C - 1), .RDPRE_L(RDPRE_C - 1),
      .WRPRE_L(WRPRE_C - 1), .RASMAX(RASMX_C)
    ) u_bank (
      .clk(clk), .rst(rst), .issue(issue), .cmd(cmd),
      .sel(req_bank == b), .act_rdy(act_rdy[b]), .col_rdy(col_rdy[b]),
      .pre_rdy(pre_rdy[b]), .is_open(open_v[b]), .ras_over(over_v[b])
    );
  end

  sdram_gap_counter #(.W(CNT_W)) u_rrd (.clk(clk), .rst(rst),
    .load(issue && cmd == CMD_ACT), .val(CNT_W'(RRD_C - 1)), .idle(rrd_idle));
  sdram_gap_counter #(.W(CNT_W)) u_mrd (.clk(clk), .rst(rst),
    .load(issue && cmd == CMD_MRS), .val(CNT_W'(MRD_CYC - 1)), .idle(mrd_idle));
  sdram_gap_counter #(.W(CNT_W)) u_rfc (.clk(clk), .rst(rst),
    .load(issue && cmd == CMD_REF), .val(CNT_W'(RFC_C - 1)), .idle(rfc_idle));

  always_comb begin
    case (cmd)
      CMD_ACT:        ok = act_rdy[req_bank] && rrd_idle && mrd_idle && rfc_idle;
      CMD_RD, CMD_WR: ok = col_rdy[req_bank] && rfc_idle;
      CMD_PRE:        ok = pre_rdy[req_bank] && rfc_idle;
      CMD_REF,
      CMD_MRS:        ok = (&act_rdy) && mrd_idle && rfc_idle;
      default:        ok = 1'b1;
    endcase
  end

  assign grant = req_valid && ok;
  assign issue = req_valid && (ok || req_force);

  always_ff @(posedge clk) begin
    if (rst) viol_q <= 1'b0;
    else     viol_q <= viol_q || (req_valid && req_force && !ok) || (|over_v);
  end

  assign violation = viol_q;

  // R10: forced ungranted command raises the flag, which then holds
  p_forced_flag_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_force && !grant |=> violation);
  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);
  // R4: a granted column command targets an open bank
  p_col_open_r4: assert property (@(posedge clk) disable iff (rst)
    grant && (cmd == CMD_RD || cmd == CMD_WR) |-> open_v[req_bank]);
  // R8: refresh only with every bank closed, then a quiet cycle
  p_ref_closed_r8: assert property (@(posedge clk) disable iff (rst)
    grant && cmd == CMD_REF |-> (open_v == '0));
  p_rfc_block_r8: assert property (@(posedge clk) disable iff (rst)
    (RFC_C > 1) && grant && cmd == CMD_REF |=> !(grant && cmd != CMD_NOP));
  // R2: mode load is followed by a cycle without activate or refresh
  p_mrd_gap_r2: assert property (@(posedge clk) disable iff (rst)
    (MRD_CYC > 1) && grant && cmd == CMD_MRS
    |=> !(grant && (cmd == CMD_ACT || cmd == CMD_REF)));
  // R11: an overlong open row is flagged
  p_ras_over_r11: assert property (@(posedge clk) disable iff (rst)
    (|over_v) |=> violation);

endmodule

// File: tb/sdram_cmd_guard_bench.sv
module sdram_cmd_guard_bench;
  import sdram_guard_pkg::*;

  // R1 / R11: row-active maximum in cycles, ceil(100 us / 7.5 ns)
  localparam int RASMAX_CYC = (100_000_000 + 7500 - 1) / 7500;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [2:0] req_cmd = 3'd0;
  logic [1:0] req_bank = 2'd0;
  logic       req_force = 1'b0;
  logic       grant, violation;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  sdram_cmd_guard u_sdram_cmd_guard (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_cmd(req_cmd),
    .req_bank(req_bank), .req_force(req_force), .grant(grant),
    .violation(violation)
  );

  typedef struct packed {
    logic [3:0] idle;
    logic [2:0] cmd;
    logic [1:0] bank;
    logic       exp;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VEC [NV] = '{
    '{4'd0, CMD_MRS, 2'd0, 1'b1, 4'd9},  // R9 all closed
    '{4'd0, CMD_ACT, 2'd0, 1'b0, 4'd2},  // R2 one cycle after mode load
    '{4'd0, CMD_ACT, 2'd0, 1'b1, 4'd2},  // R2 released
    '{4'd0, CMD_ACT, 2'd1, 1'b0, 4'd3},  // R3 row-to-row (R1: 2 cycles)
    '{4'd0, CMD_RD,  2'd0, 1'b0, 4'd4},  // R4 activate-to-column (R1: 3)
    '{4'd0, CMD_ACT, 2'd1, 1'b1, 4'd3},  // R3 released
    '{4'd0, CMD_RD,  2'd0, 1'b1, 4'd4},  // R4 released
    '{4'd0, CMD_PRE, 2'd0, 1'b0, 4'd6},  // R6 read-to-precharge
    '{4'd0, CMD_WR,  2'd1, 1'b1, 4'd4},  // R4 write to open bank
    '{4'd0, CMD_PRE, 2'd1, 1'b0, 4'd6},  // R6 write recovery
    '{4'd0, CMD_PRE, 2'd0, 1'b0, 4'd6},  // R6 one cycle before release
    '{4'd0, CMD_PRE, 2'd0, 1'b1, 4'd6},  // R6 released
    '{4'd0, CMD_ACT, 2'd0, 1'b0, 4'd7},  // R7 precharge-to-activate (R1: 2)
    '{4'd0, CMD_ACT, 2'd0, 1'b1, 4'd7},  // R7 released
    '{4'd0, CMD_PRE, 2'd1, 1'b1, 4'd6},  // R6 write recovery done
    '{4'd0, CMD_WR,  2'd3, 1'b0, 4'd4},  // R4 closed bank
    '{4'd0, CMD_REF, 2'd0, 1'b0, 4'd8},  // R8 bank 0 open
    '{4'd2, CMD_PRE, 2'd0, 1'b0, 4'd5},  // R5 row-active minimum (R1: 7)
    '{4'd0, CMD_PRE, 2'd0, 1'b1, 4'd5},  // R5 released
    '{4'd0, CMD_REF, 2'd0, 1'b0, 4'd8},  // R8 precharge-to-activate pending
    '{4'd0, CMD_REF, 2'd0, 1'b1, 4'd8},  // R8 granted
    '{4'd0, CMD_ACT, 2'd2, 1'b0, 4'd8},  // R8 refresh cycle running
    '{4'd8, CMD_ACT, 2'd2, 1'b0, 4'd8},  // R8 last blocked cycle (R1: 11)
    '{4'd0, CMD_ACT, 2'd2, 1'b1, 4'd8},  // R8 released
    '{4'd0, CMD_MRS, 2'd0, 1'b0, 4'd9},  // R9 bank 2 open
    '{4'd0, CMD_ACT, 2'd2, 1'b0, 4'd7}   // R7 bank already open
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] c, input logic [1:0] b, input logic f);
    @(negedge clk);
    req_valid = 1'b1;
    req_cmd   = c;
    req_bank  = b;
    req_force = f;
    #2;
  endtask

  task automatic go_idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_force = 1'b0;
    end
  endtask

  initial begin
    #4_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R12 reset violation", violation, 1'b0);
    chk("R12 grant without valid", grant, 1'b0);
    rst = 1'b0;

    for (int v = 0; v < NV; v++) begin
      go_idle(int'(VEC[v].idle));
      drive(VEC[v].cmd, VEC[v].bank, 1'b0);
      chk($sformatf("R%0d vector %0d", VEC[v].rq, v), grant, VEC[v].exp);
    end
    go_idle(1);
    chk("R10 no forced command yet", violation, 1'b0);

    // R10: forced activate to the open bank
    drive(CMD_ACT, 2'd2, 1'b1);
    chk("R10 forced command not granted", grant, 1'b0);
    go_idle(1);
    chk("R10 flag set", violation, 1'b1);
    go_idle(4);
    chk("R10 flag sticky", violation, 1'b1);

    // R12: reset clears the flag; grant needs valid
    @(negedge clk);
    rst = 1'b1;
    req_cmd = CMD_ACT;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #2;
    chk("R12 flag cleared by reset", violation, 1'b0);
    chk("R12 valid low gives no grant", grant, 1'b0);

    // R11: bank 3 left open past the row-active maximum
    drive(CMD_ACT, 2'd3, 1'b0);
    chk("R11 activate after reset", grant, 1'b1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (RASMAX_CYC - 1) @(posedge clk);
    #2;
    chk("R11 still within row-active maximum", violation, 1'b0);
    @(posedge clk);
    #2;
    chk("R11 row-active maximum exceeded", violation, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule